// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns a 32-bit effective address into a real page number by way of a 16-entry segment register file and a hashed page table held in memory. A request names the address, whether it is a write, whether it is an instruction fetch and whether the requester runs in user mode. The walker picks a segment register from the top address nibble. It derives a primary group address from the virtual segment id, the page index and the table-base input, then scans the eight two-word entries of that group through a word-wide memory port. When nothing in the primary group matches, it scans the secondary group.

For the entry that hits, the walker decodes the page protection under the segment's key. It sets the referenced bit and, on a permitted write, the changed bit. It writes the second word back only when one of those bits actually flipped. Each walk ends with a one-cycle done pulse carrying a status code, the real page number and the read/write permissions. Direct-store segments are reported with their own status and no table access.

Memory requests use valid/ready. A request stays asserted with address, direction and data unchanged until ready is seen high at a clock edge. Only one read is outstanding at a time, and it completes with exactly one read-data valid pulse. A write completes on acceptance and takes no response. The request side takes a new walk only while `req_ready` is high.

Top module: `hpt_walker`

## Requirements
- R1: The segment register used for a walk is the one indexed by ea[31:28], as last written through the segment write port. Its low 24 bits form the virtual segment id, and ea[27:12] forms the page index.
- R2: When bit 31 of the selected segment register is set, the walk ends with status 4 (direct store), permissions 0 and no memory access.
- R3: An instruction fetch through a segment whose bit 28 is set (and bit 31 clear) ends with status 3 (no-execute) and no memory access. A data access through the same segment walks the table normally.
- R4: The primary group address is (base & 0xFFFF0000) | (H & M), where H = ((vsid ^ pgidx) & 0x7FFFF) << 6 and M = (base[8:0] << 16) | 0xFFC0. Entry i has its first word at group + 8*i and its second word at group + 8*i + 4. All entries are read in ascending order.
- R5: An entry matches when first-word bit 31 is set, first-word bit 6 equals the group-select bit (0 primary, 1 secondary), and (word0 & 0x7FFFFFBF) equals (vsid << 7) | (pgidx >> 10).
- R6: The secondary group, with H replaced by (~H) & 0x01FFFFC0, is scanned only when the primary group yields no usable match.
- R7: When neither group yields a usable match, the walk ends with status 1 (no match), permissions 0 and RPN 0.
- R8: When two matches in one group differ in any second-word bit under 0xFFFFF07B, that group counts as having no match. Its scan stops at the conflicting entry and it is never written. Matches differing only outside that mask count as one hit on the first of them.
- R9: The key is 1 when (segment bit 29 and user mode) or (segment bit 30 and supervisor mode), else 0. With key 0, read is allowed, and write is allowed unless pp = word1[1:0] is 3. With key 1, pp 0 gives nothing, pp 2 gives read/write, and pp 1 or 3 give read only. A fetch needs read. A denied access ends with status 2 (protection), while a granted one ends with status 0 (hit), with RPN = word1[31:12] in both cases.
- R10: After a hit or a protection fault, bit 8 (referenced) of the first match's second word is set, and bit 7 (changed) is set only for a granted write. The word is written back to its address only when its value changed.
- R11: Write permission is reported only when the changed bit is set after the update.
- R12: A memory request holds address, direction and data stable until accepted. No new read is issued while a read is outstanding.
- R13: `req_ready` is high only when idle. `done` is a one-cycle pulse after which `req_ready` returns high, and the result outputs hold until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Segment register write strobe |
| sr_idx | input | 4 | Segment register index to write |
| sr_wdata | input | 32 | Segment register write value |
| tbl_base | input | 32 | Page table base and size mask |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_ea | input | 32 | Effective address to translate |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Requester in user mode |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory request is a write |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| res_status | output | 3 | 0 hit, 1 no match, 2 protection, 3 no-execute, 4 direct store |
| res_rpn | output | 20 | Real page number |
| res_read | output | 1 | Read permitted |
| res_write | output | 1 | Write permitted |

## Verification
Page table images are built with decoy entries: one with the valid bit clear, one with the wrong segment id and one with the wrong group-select bit next to the true entry. These separate a correct match test from one that ignores any of its three terms. Walks repeat on the same page as read, write and read again, which tells a correct referenced/changed update and write-back from one that writes every time or never. The protection matrix is covered through user and supervisor key selection, together with the no-match, conflicting-duplicate, secondary-only, direct-store and no-execute cases. Each of these is also told apart by its count of memory reads and writes. A non-zero table-size mask with a hand-computed group address checks the group formula itself, while the memory side throttles ready and delays read data throughout.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [2:0] {
    ST_HIT     = 3'd0,
    ST_NOMATCH = 3'd1,
    ST_PROT    = 3'd2,
    ST_NOEXEC  = 3'd3,
    ST_DSTORE  = 3'd4
  } walk_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WAIT, S_EVAL, S_WB, S_DONE
  } walk_state_e;

  // first-word compare mask (drops valid and group-select bits)
  localparam logic [31:0] TAG_MASK     = 32'h7FFF_FFBF;
  // second-word bits that duplicate matches must agree on
  localparam logic [31:0] AGREE_MASK   = 32'hFFFF_F07B;
  localparam logic [31:0] REF_FLAG     = 32'h0000_0100;
  localparam logic [31:0] CHG_FLAG     = 32'h0000_0080;

endpackage

// File: rtl/hptw_segfile.sv
module hptw_segfile #(
  parameter int unsigned SEG_COUNT = 16,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [SEG_COUNT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        regs[i] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/hptw_hash.sv
module hptw_hash (
  input  logic [23:0] vsid,
  input  logic [15:0] pgidx,
  input  logic [31:0] base,
  input  logic        ks,
  input  logic        kp,
  input  logic        user,
  output logic [31:0] pri_grp,
  output logic [31:0] sec_grp,
  output logic [31:0] tag,
  output logic        key
);
  logic [23:0] mix;
  logic [24:0] h_pri, h_sec;
  logic [31:0] size_mask, base_hi;
  logic [6:0]  unused_base;

  assign mix       = vsid ^ {8'h00, pgidx};
  assign h_pri     = {mix[18:0], 6'b0};
  assign h_sec     = ~h_pri & 25'h1FF_FFC0;
  assign size_mask = {7'd0, base[8:0], 16'hFFC0};
  assign base_hi   = {base[31:16], 16'h0000};
  assign pri_grp   = base_hi | ({7'd0, h_pri} & size_mask);
  assign sec_grp   = base_hi | ({7'd0, h_sec} & size_mask);
  assign tag       = {1'b0, vsid, 1'b0, pgidx[15:10]};
  assign key       = (kp & user) | (ks & ~user);
  assign unused_base = base[15:9];
endmodule

// File: rtl/hptw_prot.sv
module hptw_prot (
  input  logic       key,
  input  logic [1:0] pp,
  output logic       can_read,
  output logic       can_write
);
  always_comb begin
    if (!key) begin
      can_read  = 1'b1;
      can_write = (pp != 2'b11);
    end else begin
      unique case (pp)
        2'b00:   begin can_read = 1'b0; can_write = 1'b0; end
        2'b10:   begin can_read = 1'b1; can_write = 1'b1; end
        default: begin can_read = 1'b1; can_write = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int unsigned GROUP_ENTRIES = 8,
  parameter int unsigned SEG_COUNT     = 16,
  localparam int unsigned IDX_W        = $clog2(GROUP_ENTRIES),
  localparam int unsigned SEG_IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sr_we,
  input  logic [SEG_IDX_W-1:0] sr_idx,
  input  logic [31:0]          sr_wdata,
  input  logic [31:0]          tbl_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_ea,
  input  logic                 req_write,
  input  logic                 req_fetch,
  input  logic                 req_user,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [31:0]          mem_addr,
  output logic                 mem_we,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata,
  output logic                 done,
  output logic [2:0]           res_status,
  output logic [19:0]          res_rpn,
  output logic                 res_read,
  output logic                 res_write
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_state_e      state;
  logic [31:0]      seg_rd;
  logic [23:0]      vsid_q;
  logic [15:0]      pg_q;
  logic             ks_q, kp_q, user_q, wr_q;
  logic             hsel_q, word_q, found_q, bad_q;
  logic [IDX_W-1:0] idx_q, good_q;
  logic [31:0]      w0_q, keep_q, wb_q;
  logic [2:0]       st_q;
  logic [19:0]      rpn_q;
  logic             rd_q, wrp_q;
  logic [15:0]      unused_bits;

  logic [31:0] pri_grp, sec_grp, tag, grp, off;
  logic        key, can_read, can_write;
  logic        hit_now, clash, granted, usable;
  logic [31:0] upd;

  hptw_segfile #(.SEG_COUNT(SEG_COUNT), .DATA_W(32)) u_seg (
    .clk(clk), .rst_n(rst_n), .wr_en(sr_we), .wr_idx(sr_idx),
    .wr_data(sr_wdata), .rd_idx(req_ea[31 -: SEG_IDX_W]), .rd_data(seg_rd)
  );

  hptw_hash u_hash (
    .vsid(vsid_q), .pgidx(pg_q), .base(tbl_base), .ks(ks_q), .kp(kp_q),
    .user(user_q), .pri_grp(pri_grp), .sec_grp(sec_grp), .tag(tag), .key(key)
  );

  hptw_prot u_prot (
    .key(key), .pp(keep_q[1:0]), .can_read(can_read), .can_write(can_write)
  );

  assign unused_bits = {req_ea[11:0], seg_rd[27:24]};

  // entry addressing within the selected group
  assign grp = hsel_q ? sec_grp : pri_grp;
  assign off = (state == S_WB) ? ((32'(good_q) << 3) + 32'd4)
                               : ((32'(idx_q) << 3) + (word_q ? 32'd4 : 32'd0));

  assign mem_addr  = grp + off;
  assign mem_valid = (state == S_RD) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = wb_q;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);

  // entry match and duplicate agreement, evaluated on second-word arrival
  assign hit_now = w0_q[31] && (w0_q[6] == hsel_q) && ((w0_q & TAG_MASK) == tag);
  assign clash   = hit_now && found_q && (((keep_q ^ mem_rdata) & AGREE_MASK) != 32'd0);

  // group resolution
  assign usable  = found_q && !bad_q;
  assign granted = wr_q ? can_write : can_read;
  assign upd     = keep_q | REF_FLAG |
                   ((!keep_q[7] && wr_q && granted) ? CHG_FLAG : 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vsid_q  <= '0; pg_q <= '0;
      ks_q    <= 1'b0; kp_q <= 1'b0; user_q <= 1'b0; wr_q <= 1'b0;
      hsel_q  <= 1'b0; word_q <= 1'b0; found_q <= 1'b0; bad_q <= 1'b0;
      idx_q   <= '0; good_q <= '0;
      w0_q    <= '0; keep_q <= '0; wb_q <= '0;
      st_q    <= ST_HIT; rpn_q <= '0; rd_q <= 1'b0; wrp_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          vsid_q <= seg_rd[23:0];
          pg_q   <= req_ea[27:12];
          ks_q   <= seg_rd[30];
          kp_q   <= seg_rd[29];
          user_q <= req_user;
          wr_q   <= req_write && !req_fetch;
          hsel_q <= 1'b0; idx_q <= '0; word_q <= 1'b0;
          found_q <= 1'b0; bad_q <= 1'b0;
          if (seg_rd[31] || (req_fetch && seg_rd[28])) begin
            st_q  <= seg_rd[31] ? ST_DSTORE : ST_NOEXEC;
            rpn_q <= '0; rd_q <= 1'b0; wrp_q <= 1'b0;
            state <= S_DONE;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: if (mem_ready) state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (!word_q) begin
            w0_q   <= mem_rdata;
            word_q <= 1'b1;
            state  <= S_RD;
          end else begin
            word_q <= 1'b0;
            if (hit_now && !found_q) begin
              found_q <= 1'b1;
              keep_q  <= mem_rdata;
              good_q  <= idx_q;
            end
            if (clash) bad_q <= 1'b1;
            if (clash || idx_q == LAST_IDX) begin
              state <= S_EVAL;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= S_RD;
            end
          end
        end
        S_EVAL: begin
          if (usable) begin
            st_q  <= granted ? ST_HIT : ST_PROT;
            rpn_q <= keep_q[31:12];
            rd_q  <= can_read;
            wrp_q <= can_write && upd[7];
            wb_q  <= upd;
            state <= (upd != keep_q) ? S_WB : S_DONE;
          end else if (!hsel_q) begin
            hsel_q  <= 1'b1; idx_q <= '0; word_q <= 1'b0;
            found_q <= 1'b0; bad_q <= 1'b0;
            state   <= S_RD;
          end else begin
            st_q  <= ST_NOMATCH;
            rpn_q <= '0; rd_q <= 1'b0; wrp_q <= 1'b0;
            state <= S_DONE;
          end
        end
        S_WB:   if (mem_ready) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign res_status = st_q;
  assign res_rpn    = rpn_q;
  assign res_read   = rd_q;
  assign res_write  = wrp_q;
endmodule

// File: rtl/hptw_walker_chk.sv
module hptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_rvalid,
  input logic        done,
  input logic [2:0]  res_status,
  input logic        res_read
);
  logic rd_out;

  always_ff @(posedge clk) begin
    if (!rst_n)                                rd_out <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we) rd_out <= 1'b1;
    else if (mem_rvalid)                        rd_out <= 1'b0;
  end

  // R12: a stalled request keeps its contents
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

  // R12: no second read while one is outstanding
  a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !(mem_valid && !mem_we));

  // R13: done lasts one cycle and the walker is idle right after
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R13: an accepted request makes the walker busy
  a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R10: every write-back carries the referenced bit
  a_r10_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[8]);

  // R9: a granted walk always permits reading
  a_r9_hit_reads: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_status == 3'd0 |-> res_read);
endmodule

bind hpt_walker hptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .done(done), .res_status(res_status), .res_read(res_read)
);

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] tbl_base = 32'h0010_0000;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_ea = '0;
  logic        req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  res_status;
  logic [19:0] res_rpn;
  logic        res_read, res_write;

  always #2 clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_idx(sr_idx), .sr_wdata(sr_wdata),
    .tbl_base(tbl_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .res_status(res_status), .res_rpn(res_rpn),
    .res_read(res_read), .res_write(res_write)
  );

  int n_chk = 0, n_bad = 0;
  int rd_count = 0, wr_count = 0;
  logic [31:0] mem_img [logic [31:0]];
  logic [24:0] exp_q [$];
  string       tag_q [$];

  localparam logic [31:0] SR0 = 32'h0000_0123;
  localparam logic [31:0] SR1 = 32'h2000_0456;
  localparam logic [31:0] SR2 = 32'h1000_0789;
  localparam logic [31:0] SR3 = 32'h8000_0000;
  localparam logic [31:0] SR4 = 32'h4000_0ABC;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] grp_of(input logic [31:0] sr, input logic [31:0] ea,
                                          input logic [31:0] base, input bit sec);
    logic [31:0] h, m;
    h = ((((sr & 32'h00FF_FFFF) ^ ((ea >> 12) & 32'hFFFF)) & 32'h7FFFF) << 6);
    if (sec) h = ~h & 32'h01FF_FFC0;
    m = ((base & 32'h1FF) << 16) | 32'hFFC0;
    return (base & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] w0_of(input logic [31:0] sr, input logic [31:0] ea, input bit h);
    return 32'h8000_0000 | ((sr & 32'h00FF_FFFF) << 7) | (32'(h) << 6) |
           (((ea >> 12) & 32'hFFFF) >> 10);
  endfunction

  task automatic put(input logic [31:0] g, input int slot, input logic [31:0] w0, input logic [31:0] w1);
    mem_img[g + 32'(slot) * 8]     = w0;
    mem_img[g + 32'(slot) * 8 + 4] = w1;
  endtask

  task automatic set_sr(input logic [3:0] i, input logic [31:0] v);
    @(negedge clk);
    sr_we = 1'b1; sr_idx = i; sr_wdata = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  // memory model: throttled ready, delayed read data, posted writes
  initial begin : responder
    int stall = 0;
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rvalid = 1'b1; mem_rdata = mrd(paddr); pend = 0;
        end else dly--;
      end
      stall++;
      mem_ready = (stall % 3) != 0;
      if (rst_n && mem_ready && mem_valid) begin
        if (mem_we) begin
          mem_img[mem_addr] = mem_wdata; wr_count++;
        end else begin
          rd_count++; pend = 1; dly = stall % 2; paddr = mem_addr;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R13 unexpected done", 64'd1, 64'd0);
        end else begin
          logic [24:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({res_status, res_read, res_write, res_rpn} == e, t,
                {res_status, res_read, res_write, res_rpn}, e);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] ea, input bit wr, input bit fe, input bit us,
                      input logic [2:0] st, input bit rd_ok, input bit wr_ok,
                      input logic [19:0] rpn, input int exp_rd, input int exp_wr,
                      input string rq);
    int r0, w0;
    exp_q.push_back({st, rd_ok, wr_ok, rpn});
    tag_q.push_back({rq, " result"});
    r0 = rd_count; w0 = wr_count;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_write = wr; req_fetch = fe; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
    if (exp_rd >= 0)
      check(rd_count - r0 == exp_rd, {rq, " reads"}, 64'(rd_count - r0), 64'(exp_rd));
    check(wr_count - w0 == exp_wr, {rq, " writes"}, 64'(wr_count - w0), 64'(exp_wr));
    check(!done && req_ready, "R13 idle after done", {62'd0, done, req_ready}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] g;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !mem_valid, "R13 reset state",
          {61'd0, req_ready, done, mem_valid}, 64'h4);
    rst_n = 1'b1;
    set_sr(4'd0, SR0); set_sr(4'd1, SR1); set_sr(4'd2, SR2);
    set_sr(4'd3, SR3); set_sr(4'd4, SR4);

    // R1 R4 R5 R11: decoys then true entry in slot 3
    g = grp_of(SR0, 32'h0000_5000, tbl_base, 0);
    put(g, 0, w0_of(SR0, 32'h0000_5000, 0) & 32'h7FFF_FFFF, 32'h9999_9002);
    put(g, 1, w0_of(32'h124, 32'h0000_5000, 0), 32'h8888_8002);
    put(g, 2, w0_of(SR0, 32'h0000_5000, 1), 32'h7777_7002);
    put(g, 3, w0_of(SR0, 32'h0000_5000, 0), 32'h0ABC_D002);
    walk(32'h0000_5000, 0, 0, 0, 3'd0, 1, 0, 20'h0ABCD, 16, 1, "R5 R11 first read");
    check(mrd(g + 28) == 32'h0ABC_D102, "R10 referenced write-back", mrd(g + 28), 32'h0ABC_D102);
    check(mrd(g + 4) == 32'h9999_9002, "R5 invalid entry untouched", mrd(g + 4), 32'h9999_9002);
    walk(32'h0000_5000, 1, 0, 0, 3'd0, 1, 1, 20'h0ABCD, 16, 1, "R10 first write");
    check(mrd(g + 28) == 32'h0ABC_D182, "R10 changed write-back", mrd(g + 28), 32'h0ABC_D182);
    walk(32'h0000_5000, 0, 0, 0, 3'd0, 1, 1, 20'h0ABCD, 16, 0, "R10 R11 no rewrite");

    // R9 R1: user key on segment 1, read-only page written
    g = grp_of(SR1, 32'h1000_7000, tbl_base, 0);
    put(g, 0, w0_of(SR1, 32'h1000_7000, 0), 32'h1111_1001);
    walk(32'h1000_7000, 1, 0, 1, 3'd2, 1, 0, 20'h11111, 16, 1, "R9 key1 pp1 write");
    check(mrd(g + 4) == 32'h1111_1101, "R10 ref on fault", mrd(g + 4), 32'h1111_1101);

    g = grp_of(SR1, 32'h1000_8000, tbl_base, 0);
    put(g, 5, w0_of(SR1, 32'h1000_8000, 0), 32'h2222_2000);
    walk(32'h1000_8000, 0, 0, 1, 3'd2, 0, 0, 20'h22222, 16, 1, "R9 key1 pp0 read");
    walk(32'h1000_8000, 0, 0, 0, 3'd0, 1, 0, 20'h22222, 16, 0, "R9 R11 key0 supervisor");

    g = grp_of(SR4, 32'h4000_3000, tbl_base, 0);
    put(g, 6, w0_of(SR4, 32'h4000_3000, 0), 32'h3333_3002);
    walk(32'h4000_3000, 1, 0, 0, 3'd0, 1, 1, 20'h33333, 16, 1, "R9 supervisor key1 pp2");
    check(mrd(g + 52) == 32'h3333_3182, "R10 R/C set", mrd(g + 52), 32'h3333_3182);

    g = grp_of(SR0, 32'h0000_6000, tbl_base, 0);
    put(g, 7, w0_of(SR0, 32'h0000_6000, 0), 32'h4444_4003);
    walk(32'h0000_6000, 1, 0, 0, 3'd2, 1, 0, 20'h44444, 16, 1, "R9 key0 pp3 write");

    // R6: fetch resolved in secondary group, primary holds wrong-select entry
    g = grp_of(SR0, 32'h0000_9000, tbl_base, 0);
    put(g, 4, w0_of(SR0, 32'h0000_9000, 1), 32'h5555_5002);
    g = grp_of(SR0, 32'h0000_9000, tbl_base, 1);
    put(g, 7, w0_of(SR0, 32'h0000_9000, 1), 32'h6666_6002);
    walk(32'h0000_9000, 0, 1, 0, 3'd0, 1, 0, 20'h66666, 32, 1, "R6 secondary fetch");

    // R7: nothing anywhere
    walk(32'h0000_A000, 0, 0, 0, 3'd1, 0, 0, 20'h0, 32, 0, "R7 no match");

    // R8: conflicting duplicates in primary, fallback to secondary
    g = grp_of(SR0, 32'h0000_B000, tbl_base, 0);
    put(g, 2, w0_of(SR0, 32'h0000_B000, 0), 32'h7700_0002);
    put(g, 5, w0_of(SR0, 32'h0000_B000, 0), 32'h7800_0002);
    put(grp_of(SR0, 32'h0000_B000, tbl_base, 1), 0, w0_of(SR0, 32'h0000_B000, 1), 32'h7900_0002);
    walk(32'h0000_B000, 0, 0, 0, 3'd0, 1, 0, 20'h79000, 28, 1, "R8 conflict");
    check(mrd(g + 20) == 32'h7700_0002, "R8 conflicting group unwritten", mrd(g + 20), 32'h7700_0002);

    // R8: duplicates differing only in R/C are one hit on the first
    g = grp_of(SR0, 32'h0000_C000, tbl_base, 0);
    put(g, 1, w0_of(SR0, 32'h0000_C000, 0), 32'h7A00_0002);
    put(g, 6, w0_of(SR0, 32'h0000_C000, 0), 32'h7A00_0182);
    walk(32'h0000_C000, 0, 0, 0, 3'd0, 1, 0, 20'h7A000, 16, 1, "R8 agreeing duplicates");
    check(mrd(g + 12) == 32'h7A00_0102, "R8 first match written", mrd(g + 12), 32'h7A00_0102);

    // R2 R3
    walk(32'h3000_0000, 0, 0, 0, 3'd4, 0, 0, 20'h0, 0, 0, "R2 direct store");
    walk(32'h2000_1000, 0, 1, 0, 3'd3, 0, 0, 20'h0, 0, 0, "R3 no-execute fetch");
    walk(32'h2000_1000, 0, 0, 0, 3'd1, 0, 0, 20'h0, 32, 0, "R3 data walk");

    // R4: size mask bits in the base, hand-computed group address
    tbl_base = 32'h0020_0001;
    put(32'h0021_48C0, 0, w0_of(SR0, 32'h0040_0000, 0), 32'h7B00_0002);
    walk(32'h0040_0000, 0, 0, 0, 3'd0, 1, 0, 20'h7B000, 16, 1, "R4 masked base");
    check(mrd(32'h0021_48C4) == 32'h7B00_0102, "R4 R12 write address", mrd(32'h0021_48C4), 32'h7B00_0102);

    check(exp_q.size() == 0, "R13 all results seen", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule